// File: doc/BRIEF.md
# Transmit Status and Interrupt Unit

This block sits beside a packet transmit engine and turns the per-packet outcome into host-visible state. The engine sends strobes: one when a packet finishes, and one for each of three error kinds (FIFO underrun, a collision after the 64-byte window, loss of carrier). It also sends a 4-bit count of the collisions seen on the current packet. The block keeps these in a last-packet status register. It also keeps an error summary: the OR of the three error flags and an excessive-collision condition, which is a count of fifteen.

When a packet finishes, the unit sets one of two interrupt flags, never both. It sets the error flag if the summary is true and the success flag otherwise. Each flag has its own mask bit. The interrupt output is high while any flag is set together with its mask bit. The host clears flags by writing ones to them.

The host starts a transmission by writing a nonzero value to two command bits. This write also clears the status kept for the previous packet. Hardware clears both command bits when the packet finishes, so the host can poll them for completion. All registers sit on a simple 8-bit read/write bus. Reads are combinational and writes take effect at the clock edge.

Top module: `txstat_irq_unit`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: A `tx_done` pulse with no error flag, no error strobe in that cycle and a count below 15 sets bit 2 (success) of the interrupt status register at address 0x09 and leaves bit 4 clear.
- R3: A `tx_done` pulse with any error (underrun, late collision, carrier lost, or count equal to 15) sets bit 4 (error) of register 0x09 and leaves bit 2 clear.
- R4: In the status register at address 0x04, bit 6 is underrun, bit 5 is late collision and bit 4 is carrier lost. Bit 7 reads as the OR of bits 6, 5 and 4 and of the condition "bits 3:0 equal 15".
- R5: On `tx_done`, bits 3:0 of register 0x04 take the value of `tx_coll_cnt`. This holds for successful packets as well as failed ones.
- R6: Error bits in 0x04 are set by their strobes at any time and stay set. A write of a nonzero value to bits 1:0 of address 0x00 clears them and the count.
- R7: Bits 1:0 of address 0x00 store the written value. Bits 7:2 read 0. Both stored bits are cleared in the cycle after `tx_done`.
- R8: Writing a 1 to bit 2 or bit 4 of 0x09 clears that flag. Writing 0 has no effect. A flag that is set and cleared in the same cycle ends up set.
- R9: `irq` is high exactly when a flag in 0x09 is set and the same bit is set in the mask register at address 0x08. A flag whose mask bit is clear does not raise `irq`.
- R10: The mask register stores only bits 2 and 4. Its other bits read 0.
- R11: Reads of unmapped addresses return 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_done | input | 1 | Packet finished (one-cycle pulse) |
| tx_underrun | input | 1 | Underrun strobe |
| tx_late_coll | input | 1 | Out-of-window collision strobe |
| tx_carrier_lost | input | 1 | Carrier lost strobe |
| tx_coll_cnt | input | 4 | Collision count of the current packet |
| irq | output | 1 | Host interrupt |

## Verification
The completion path is driven with a clean packet carrying a few collisions, and with each of the three error strobes alone. It is also driven at the counts 14 and 15. These cases separate success from error and check the excessive-collision threshold on both sides. A strobe that arrives before the finish pulse checks that the error is held until the finish and then cleared by a new start. Flag clears that coincide with a new flag, writes of zero, and mask combinations check the write-1-to-clear path and the interrupt gating.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int CMDW = 2;

    // status register bit positions
    localparam int ST_SUM = 7;
    localparam int ST_UDR = 6;
    localparam int ST_LATE = 5;
    localparam int ST_CRS = 4;

    // interrupt status / mask bit positions
    localparam int IR_OK = 2;
    localparam int IR_ERR = 4;

    typedef struct packed {
        logic          udr;
        logic          late;
        logic          crs;
        logic [CW-1:0] cnt;
    } cap_t;

    typedef struct packed {
        logic ok;
        logic err;
    } irq_t;
endpackage

// File: rtl/txstat_capture.sv
module txstat_capture
    import txstat_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_clr,
    input  logic          tx_done,
    input  logic          udr_i,
    input  logic          late_i,
    input  logic          crs_i,
    input  logic [CW-1:0] cnt_i,
    output logic [DW-1:0] status_o,
    output logic          err_now_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (start_clr) begin
            cap_d = '0;
        end
        cap_d.udr  = cap_d.udr  | udr_i;
        cap_d.late = cap_d.late | late_i;
        cap_d.crs  = cap_d.crs  | crs_i;
        if (tx_done) begin
            cap_d.cnt = cnt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        status_o           = '0;
        status_o[CW-1:0]   = cap_q.cnt;
        status_o[ST_UDR]   = cap_q.udr;
        status_o[ST_LATE]  = cap_q.late;
        status_o[ST_CRS]   = cap_q.crs;
        status_o[ST_SUM]   = cap_q.udr | cap_q.late | cap_q.crs | (cap_q.cnt == CNT_MAX);
    end

    // error decision for a packet finishing this cycle
    assign err_now_o = cap_q.udr | cap_q.late | cap_q.crs | udr_i | late_i | crs_i
                     | (cnt_i == CNT_MAX);

    // R5
    cnt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> cap_q.cnt == $past(cnt_i));

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_clr && !udr_i && !late_i && !crs_i) |=> !cap_q.udr && !cap_q.late && !cap_q.crs);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.udr && !start_clr) |=> cap_q.udr);
endmodule

// File: rtl/txstat_cmd.sv
module txstat_cmd
    import txstat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [CMDW-1:0] cmd_wdata,
    input  logic            tx_done,
    output logic [CMDW-1:0] cmd_o,
    output logic            start_o
);
    logic [CMDW-1:0] cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (tx_done) cmd_d = '0;
        if (cmd_we)  cmd_d = cmd_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_o   = cmd_q;
    assign start_o = cmd_we && (cmd_wdata != '0);

    // R7
    done_clears_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !cmd_we) |=> cmd_q == '0);
endmodule

// File: rtl/txstat_irqctl.sv
module txstat_irqctl
    import txstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_done,
    input  logic tx_err,
    input  logic mask_we,
    input  logic flag_we,
    input  logic wd_ok,
    input  logic wd_err,
    output irq_t mask_o,
    output irq_t flag_o,
    output logic irq_o
);
    typedef struct packed {
        irq_t mask;
        irq_t flag;
    } ic_t;

    ic_t ic_d, ic_q;
    irq_t gated;

    always_comb begin
        ic_d = ic_q;
        if (mask_we) begin
            ic_d.mask.ok  = wd_ok;
            ic_d.mask.err = wd_err;
        end
        if (flag_we) begin
            if (wd_ok)  ic_d.flag.ok  = 1'b0;
            if (wd_err) ic_d.flag.err = 1'b0;
        end
        if (tx_done) begin
            if (tx_err) ic_d.flag.err = 1'b1;
            else        ic_d.flag.ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ic_q <= '0;
        else        ic_q <= ic_d;
    end

    assign gated  = ic_q.flag & ic_q.mask;
    assign irq_o  = |gated;
    assign mask_o = ic_q.mask;
    assign flag_o = ic_q.flag;

    // R2
    ok_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_err) |=> ic_q.flag.ok);

    // R3
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_err) |=> ic_q.flag.err);

    // R3
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_err && !ic_q.flag.ok) |=> !ic_q.flag.ok);

    // R8
    w1c_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wd_ok && !tx_done) |=> !ic_q.flag.ok);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(tx_done) || $past(mask_we)));
endmodule

// File: rtl/txstat_irq_unit.sv
module txstat_irq_unit
    import txstat_pkg::*;
#(
    parameter int              AW       = 8,
    parameter logic [AW-1:0]   A_CMD    = 8'h00,
    parameter logic [AW-1:0]   A_STATUS = 8'h04,
    parameter logic [AW-1:0]   A_MASK   = 8'h08,
    parameter logic [AW-1:0]   A_FLAG   = 8'h09
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          tx_done,
    input  logic          tx_underrun,
    input  logic          tx_late_coll,
    input  logic          tx_carrier_lost,
    input  logic [CW-1:0] tx_coll_cnt,
    output logic          irq
);
    logic            cmd_we, mask_we, flag_we, start_clr, err_now;
    logic [CMDW-1:0] cmd_val;
    logic [DW-1:0]   status_val;
    irq_t            mask_val, flag_val;
    logic            wdata_unused;

    assign cmd_we  = reg_wr && (reg_addr == A_CMD);
    assign mask_we = reg_wr && (reg_addr == A_MASK);
    assign flag_we = reg_wr && (reg_addr == A_FLAG);
    assign wdata_unused = ^reg_wdata;

    txstat_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (reg_wdata[CMDW-1:0]),
        .tx_done   (tx_done),
        .cmd_o     (cmd_val),
        .start_o   (start_clr)
    );

    txstat_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_clr (start_clr),
        .tx_done   (tx_done),
        .udr_i     (tx_underrun),
        .late_i    (tx_late_coll),
        .crs_i     (tx_carrier_lost),
        .cnt_i     (tx_coll_cnt),
        .status_o  (status_val),
        .err_now_o (err_now)
    );

    txstat_irqctl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_done (tx_done),
        .tx_err  (err_now),
        .mask_we (mask_we),
        .flag_we (flag_we),
        .wd_ok   (reg_wdata[IR_OK]),
        .wd_err  (reg_wdata[IR_ERR]),
        .mask_o  (mask_val),
        .flag_o  (flag_val),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CMD) begin
            reg_rdata[CMDW-1:0] = cmd_val;
        end else if (reg_addr == A_STATUS) begin
            reg_rdata = status_val;
        end else if (reg_addr == A_MASK) begin
            reg_rdata[IR_OK]  = mask_val.ok;
            reg_rdata[IR_ERR] = mask_val.err;
        end else if (reg_addr == A_FLAG) begin
            reg_rdata[IR_OK]  = flag_val.ok;
            reg_rdata[IR_ERR] = flag_val.err;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

// File: tb/tb_txstat_irq_unit.sv
`timescale 1ns/1ps
module tb_txstat_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_done = 1'b0;
    logic       tx_underrun = 1'b0;
    logic       tx_late_coll = 1'b0;
    logic       tx_carrier_lost = 1'b0;
    logic [3:0] tx_coll_cnt = '0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    txstat_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done),
        .tx_underrun(tx_underrun), .tx_late_coll(tx_late_coll),
        .tx_carrier_lost(tx_carrier_lost), .tx_coll_cnt(tx_coll_cnt), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic finish_pkt(input logic u, input logic l, input logic c, input logic [3:0] n);
        @(negedge clk);
        tx_done = 1'b1; tx_underrun = u; tx_late_coll = l; tx_carrier_lost = c; tx_coll_cnt = n;
        @(negedge clk);
        tx_done = 1'b0; tx_underrun = 1'b0; tx_late_coll = 1'b0; tx_carrier_lost = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h00, v); chk("R1 cmd", v, 8'h00);
        rd(8'h04, v); chk("R1 status", v, 8'h00);
        rd(8'h08, v); chk("R1 mask", v, 8'h00);
        rd(8'h09, v); chk("R1 flags", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_clean_success();
        logic [7:0] v;
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'h01);
        finish_pkt(0, 0, 0, 4'd3);
        rd(8'h04, v); chk("R5 count on success", v, 8'h03);
        rd(8'h09, v); chk("R2 success flag", v, 8'h04);
        rd(8'h00, v); chk("R7 cmd cleared", v, 8'h00);
    endtask

    task automatic t_each_error();
        logic [7:0] v;
        for (int k = 0; k < 3; k++) begin
            wr(8'h09, 8'hFF);
            wr(8'h00, 8'h01);
            finish_pkt(k == 0, k == 1, k == 2, 4'd2);
            rd(8'h04, v); chk("R4 summary and cause", v, 8'h82 | (8'h40 >> k));
            rd(8'h09, v); chk("R3 error flag", v, 8'h10);
        end
    endtask

    task automatic t_count_edge();
        logic [7:0] v;
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'h02);
        finish_pkt(0, 0, 0, 4'd14);
        rd(8'h04, v); chk("R4 count 14 no summary", v, 8'h0E);
        rd(8'h09, v); chk("R2 count 14 success", v, 8'h04);
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'h02);
        finish_pkt(0, 0, 0, 4'd15);
        rd(8'h04, v); chk("R4 excessive summary", v, 8'h8F);
        rd(8'h09, v); chk("R3 excessive error", v, 8'h10);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'h01);
        @(negedge clk); tx_carrier_lost = 1'b1;
        @(negedge clk); tx_carrier_lost = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h04, v); chk("R6 held before done", v, 8'h90);
        rd(8'h09, v); chk("R6 no flag before done", v, 8'h00);
        finish_pkt(0, 0, 0, 4'd1);
        rd(8'h04, v); chk("R6 held at done", v, 8'h91);
        rd(8'h09, v); chk("R3 earlier strobe error", v, 8'h10);
        wr(8'h00, 8'h00);
        rd(8'h04, v); chk("R6 zero cmd keeps", v, 8'h91);
        wr(8'h00, 8'h02);
        rd(8'h04, v); chk("R6 start clears", v, 8'h00);
    endtask

    task automatic t_cmd();
        logic [7:0] v;
        wr(8'h00, 8'h03);
        rd(8'h00, v); chk("R7 cmd store", v, 8'h03);
        wr(8'h00, 8'hFE);
        rd(8'h00, v); chk("R7 upper bits zero", v, 8'h02);
        finish_pkt(0, 0, 0, 4'd0);
        rd(8'h00, v); chk("R7 done clears", v, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wr(8'h09, 8'hFF);
        wr(8'h00, 8'h01);
        finish_pkt(0, 0, 0, 4'd0);
        wr(8'h09, 8'h00);
        rd(8'h09, v); chk("R8 write zero no effect", v, 8'h04);
        wr(8'h09, 8'h10);
        rd(8'h09, v); chk("R8 other bit no effect", v, 8'h04);
        wr(8'h09, 8'h04);
        rd(8'h09, v); chk("R8 clear", v, 8'h00);
        wr(8'h00, 8'h01);
        @(negedge clk);
        reg_addr = 8'h09; reg_wdata = 8'h04; reg_wr = 1'b1; tx_done = 1'b1; tx_coll_cnt = 4'd0;
        @(negedge clk);
        reg_wr = 1'b0; tx_done = 1'b0;
        rd(8'h09, v); chk("R8 set wins", v, 8'h04);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(8'h09, 8'hFF);
        wr(8'h08, 8'h00);
        wr(8'h00, 8'h01);
        finish_pkt(0, 0, 0, 4'd0);
        chk("R9 masked no irq", {7'b0, irq}, 8'h00);
        wr(8'h08, 8'hFF);
        rd(8'h08, v); chk("R10 mask bits", v, 8'h14);
        chk("R9 unmasked irq", {7'b0, irq}, 8'h01);
        wr(8'h09, 8'h04);
        chk("R9 cleared irq", {7'b0, irq}, 8'h00);
        wr(8'h08, 8'h04);
        wr(8'h00, 8'h01);
        finish_pkt(1, 0, 0, 4'd0);
        chk("R9 error masked", {7'b0, irq}, 8'h00);
        wr(8'h08, 8'h10);
        chk("R9 error unmasked", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] s0, m0, f0, v;
        rd(8'h04, s0); rd(8'h08, m0); rd(8'h09, f0);
        wr(8'h05, 8'hFF);
        wr(8'h0A, 8'hFF);
        rd(8'h05, v); chk("R11 unmapped read", v, 8'h00);
        rd(8'h04, v); chk("R11 status intact", v, s0);
        rd(8'h08, v); chk("R11 mask intact", v, m0);
        rd(8'h09, v); chk("R11 flags intact", v, f0);
        rd(8'h00, v); chk("R11 cmd intact", v, 8'h00);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_success();
        t_each_error();
        t_count_edge();
        t_sticky();
        t_cmd();
        t_w1c();
        t_mask();
        t_unmapped();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule